// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper with Optional Self-Flash Strobes

This block holds the banking logic of a cartridge for an 8-bit console. It has one 8-bit control register. Writes from the CPU into the cartridge's program space load that register. From the register and the current address lines, the block forms four sets of outputs:

- the upper program-ROM address lines,
- the two upper address lines of the character RAM,
- the address line that selects half of the nametable RAM,
- the write-enable and output-enable strobes for a flash program memory.

The program space is 512 KB, divided into 32 banks of 16 KB. The lower 16 KB CPU window shows the selected bank. Each upper program line is the OR of CPU A14 with one register bit, so the upper window always shows bank 31.

Static parameters select the build variant, the character-RAM size and the nametable mirroring source. The two build variants differ as follows:

- **Locked variant.** Any write into program space loads the register. The ROM drives the bus during that write, so the stored byte is the written data ANDed with the ROM byte.
- **Flashable variant.** Only the upper window loads the register. Writes to the lower window become flash write strobes instead. There is no bus conflict, so the written data is stored unchanged.

Top module: `cart_bank_mapper`

## Requirements
- R1: The register clears to 0x00 while `rstN` is low. After reset, with `cpuA14`=0, the program lines read 0. The one-screen nametable select reads 0.
- R2: With `cpuA14`=0, `prgHigh[4:0]` equals register bits 4..0, and `prgHigh[0]` drives ROM A14.
- R3: With `cpuA14`=1, `prgHigh` is 5'h1F for every register value.
- R4: Locked variant: a clock edge loads the register when `romCeN`=0 and `cpuRw`=0, whatever the state of `cpuA14`. The value loaded is `cpuData & romData`.
- R5: Flashable variant: the register loads only when `romCeN`=0, `cpuRw`=0 and `cpuA14`=1. The value loaded is `cpuData` unchanged.
- R6: Flashable variant: `flashWeN` is low, combinationally, exactly while `romCeN`=0, `cpuRw`=0 and `cpuA14`=0. Such a write leaves the register unchanged.
- R7: `flashOeN` is low exactly while `romCeN`=0 and `cpuRw`=1 in the flashable variant. In the locked variant, `flashOeN` is held at 0 and `flashWeN` is held at 1.
- R8: `chrHigh[0]` is character-RAM A13 and `chrHigh[1]` is A14. Their values depend on the configured size:
  - 32 KB: they carry register bits 5 and 6.
  - 16 KB: A13 carries bit 5 and A14 is 1.
  - 8 KB: both are 1.
- R9: `ntA10` carries the value selected by `MIRROR_SEL`:
  - 0 (vertical): `ppuA10`.
  - 1 (horizontal): `ppuA11`.
  - 2 (one-screen): register bit 7.
- R10: A cycle with `romCeN`=1, or with `cpuRw`=1, leaves the register unchanged.
- R11: A load shows on the outputs in the cycle after the loading clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus cycle clock; loads happen on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuA14 | input | 1 | CPU address bit 14 |
| cpuRw | input | 1 | CPU read (1) / write (0) |
| romCeN | input | 1 | Program-ROM chip enable, low for CPU $8000-$FFFF |
| cpuData | input | 8 | Data written by the CPU |
| romData | input | 8 | Byte the ROM drives at the current address |
| ppuA10 | input | 1 | PPU address bit 10 |
| ppuA11 | input | 1 | PPU address bit 11 |
| prgHigh | output | 5 | Program ROM A14..A18 |
| chrHigh | output | 2 | Character RAM A13 (bit 0) and A14 (bit 1) |
| ntA10 | output | 1 | Nametable RAM A10 |
| flashWeN | output | 1 | Flash write enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |

## Verification
In a single cycle, a CPU write can load the register and also be read through the program lines. In the flashable variant, the same write can also pulse the flash write strobe. The random cycles mix writes and reads at both halves of program space with random ROM bytes, and they run three variants side by side on the same bus. Each variant's register is tracked by a bench model. In the write cycle, the combinational outputs must still show the old register value, while the strobes follow the current cycle. In the following cycle, the program lines must show the new value, ANDed with the ROM byte only in the locked variant.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef struct packed {
    logic regLoad;
    logic flashWe;
    logic flashOe;
  } mapCtrl_t;

  localparam int MIR_VERT = 0;
  localparam int MIR_HORZ = 1;
  localparam int MIR_ONE  = 2;
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl #(
  parameter bit FLASHABLE = 1'b0
) (
  input  logic                 cpuA14,
  input  logic                 cpuRw,
  input  logic                 romCeN,
  output mapper_pkg::mapCtrl_t ctrl
);
  logic cartWrite;
  logic cartRead;

  assign cartWrite = !romCeN && !cpuRw;
  assign cartRead  = !romCeN && cpuRw;

  generate
    if (FLASHABLE) begin : g_flash
      always_comb begin
        ctrl.regLoad = cartWrite && cpuA14;
        ctrl.flashWe = cartWrite && !cpuA14;
        ctrl.flashOe = cartRead;
      end
    end else begin : g_locked
      always_comb begin
        ctrl.regLoad = cartWrite;
        ctrl.flashWe = 1'b0;
        ctrl.flashOe = 1'b1;
      end
      logic unusedRead;
      assign unusedRead = cartRead & cpuA14;
    end
  endgenerate
endmodule

// File: rtl/mapper_datapath.sv
module mapper_datapath #(
  parameter bit FLASHABLE  = 1'b0,
  parameter int CHR_KB     = 32,
  parameter int MIRROR_SEL = 2,
  parameter int REG_W      = 8,
  parameter int PRG_W      = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mapper_pkg::mapCtrl_t ctrl,
  input  logic                 cpuA14,
  input  logic [REG_W-1:0]     cpuData,
  input  logic [REG_W-1:0]     romData,
  input  logic                 ppuA10,
  input  logic                 ppuA11,
  output logic [PRG_W-1:0]     prgHigh,
  output logic [1:0]           chrHigh,
  output logic                 ntA10,
  output logic                 flashWeN,
  output logic                 flashOeN
);
  localparam int CHR_LO_BIT = PRG_W;
  localparam int CHR_HI_BIT = PRG_W + 1;
  localparam int MIR_BIT    = REG_W - 1;

  logic [REG_W-1:0] bankReg;
  logic [REG_W-1:0] conflictMask;
  logic [REG_W-1:0] loadValue;

  assign conflictMask = FLASHABLE ? {REG_W{1'b1}} : romData;
  assign loadValue    = cpuData & conflictMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bankReg <= '0;
    else if (ctrl.regLoad) bankReg <= loadValue;
  end

  genvar gi;
  generate
    for (gi = 0; gi < PRG_W; gi++) begin : g_prg
      assign prgHigh[gi] = cpuA14 | bankReg[gi];
    end

    if (CHR_KB >= 32) begin : g_chr32
      assign chrHigh = {bankReg[CHR_HI_BIT], bankReg[CHR_LO_BIT]};
    end else if (CHR_KB >= 16) begin : g_chr16
      assign chrHigh = {1'b1, bankReg[CHR_LO_BIT]};
    end else begin : g_chr8
      assign chrHigh = 2'b11;
    end

    if (MIRROR_SEL == mapper_pkg::MIR_VERT) begin : g_vert
      assign ntA10 = ppuA10;
    end else if (MIRROR_SEL == mapper_pkg::MIR_HORZ) begin : g_horz
      assign ntA10 = ppuA11;
    end else begin : g_one
      assign ntA10 = bankReg[MIR_BIT];
    end
  endgenerate

  logic unusedBits;
  assign unusedBits = ^{bankReg, ppuA10, ppuA11};

  assign flashWeN = !ctrl.flashWe;
  assign flashOeN = !ctrl.flashOe;
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter bit FLASHABLE  = 1'b0,
  parameter int CHR_KB     = 32,
  parameter int MIRROR_SEL = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuA14,
  input  logic       cpuRw,
  input  logic       romCeN,
  input  logic [7:0] cpuData,
  input  logic [7:0] romData,
  input  logic       ppuA10,
  input  logic       ppuA11,
  output logic [4:0] prgHigh,
  output logic [1:0] chrHigh,
  output logic       ntA10,
  output logic       flashWeN,
  output logic       flashOeN
);
  mapper_pkg::mapCtrl_t ctrl;

  mapper_ctrl #(.FLASHABLE(FLASHABLE)) u_ctrl (
    .cpuA14 (cpuA14),
    .cpuRw  (cpuRw),
    .romCeN (romCeN),
    .ctrl   (ctrl)
  );

  mapper_datapath #(
    .FLASHABLE (FLASHABLE),
    .CHR_KB    (CHR_KB),
    .MIRROR_SEL(MIRROR_SEL),
    .REG_W     (8),
    .PRG_W     (5)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .cpuA14  (cpuA14),
    .cpuData (cpuData),
    .romData (romData),
    .ppuA10  (ppuA10),
    .ppuA11  (ppuA11),
    .prgHigh (prgHigh),
    .chrHigh (chrHigh),
    .ntA10   (ntA10),
    .flashWeN(flashWeN),
    .flashOeN(flashOeN)
  );
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
  parameter bit FLASHABLE  = 1'b0,
  parameter int CHR_KB     = 32,
  parameter int MIRROR_SEL = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       cpuA14,
  input logic       cpuRw,
  input logic       romCeN,
  input logic [7:0] cpuData,
  input logic [7:0] romData,
  input logic       ppuA10,
  input logic       ppuA11,
  input logic [4:0] prgHigh,
  input logic [1:0] chrHigh,
  input logic       ntA10,
  input logic       flashWeN,
  input logic       flashOeN
);
  logic wrHit;
  logic [4:0] expLoad;
  assign wrHit   = !romCeN && !cpuRw && (!FLASHABLE || cpuA14);
  assign expLoad = FLASHABLE ? cpuData[4:0] : (cpuData[4:0] & romData[4:0]);

  // R3: upper window always shows the last bank
  p_fixed_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuA14 |-> prgHigh == 5'h1F);

  // R4 / R5 / R11: loaded value appears in the next cycle
  p_load_next_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> (cpuA14 || prgHigh == $past(expLoad)));

  // R10: no load keeps lower-window lines steady
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> (cpuA14 || $past(cpuA14) || $stable(prgHigh)));

  // R7: strobes never both active
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(FLASHABLE && !flashWeN && !flashOeN));

  // R6: write strobe only on a lower-window write
  p_we_decode_r6: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> (!romCeN && !cpuRw && !cpuA14));

  generate
    if (MIRROR_SEL == 0) begin : g_chk_vert
      p_mirror_vert_r9: assert property (@(posedge clk) disable iff (!rstN)
        ntA10 == ppuA10);
    end else if (MIRROR_SEL == 1) begin : g_chk_horz
      p_mirror_horz_r9: assert property (@(posedge clk) disable iff (!rstN)
        ntA10 == ppuA11);
    end
    if (CHR_KB < 16) begin : g_chk_chr8
      p_chr_small_r8: assert property (@(posedge clk) disable iff (!rstN)
        chrHigh == 2'b11);
    end
  endgenerate
endmodule

bind cart_bank_mapper mapper_checker #(
  .FLASHABLE (FLASHABLE),
  .CHR_KB    (CHR_KB),
  .MIRROR_SEL(MIRROR_SEL)
) u_chk (.*);

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuA14 = 1'b0, cpuRw = 1'b1, romCeN = 1'b1;
  logic [7:0] cpuData = '0, romData = '0;
  logic ppuA10 = 1'b0, ppuA11 = 1'b0;

  logic [4:0] prgL, prgF, prgS;
  logic [1:0] chrL, chrF, chrS;
  logic ntL, ntF, ntS, weL, weF, weS, oeL, oeF, oeS;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] mL = '0, mF = '0, mS = '0;

  always #4 clk = ~clk;

  // locked, 32 KB, one-screen
  cart_bank_mapper #(.FLASHABLE(1'b0), .CHR_KB(32), .MIRROR_SEL(2)) dut (
    .clk(clk), .rstN(rstN), .cpuA14(cpuA14), .cpuRw(cpuRw), .romCeN(romCeN),
    .cpuData(cpuData), .romData(romData), .ppuA10(ppuA10), .ppuA11(ppuA11),
    .prgHigh(prgL), .chrHigh(chrL), .ntA10(ntL), .flashWeN(weL), .flashOeN(oeL));
  // flashable, 16 KB, vertical
  cart_bank_mapper #(.FLASHABLE(1'b1), .CHR_KB(16), .MIRROR_SEL(0)) dutFlash (
    .clk(clk), .rstN(rstN), .cpuA14(cpuA14), .cpuRw(cpuRw), .romCeN(romCeN),
    .cpuData(cpuData), .romData(romData), .ppuA10(ppuA10), .ppuA11(ppuA11),
    .prgHigh(prgF), .chrHigh(chrF), .ntA10(ntF), .flashWeN(weF), .flashOeN(oeF));
  // locked, 8 KB, horizontal
  cart_bank_mapper #(.FLASHABLE(1'b0), .CHR_KB(8), .MIRROR_SEL(1)) dutSmall (
    .clk(clk), .rstN(rstN), .cpuA14(cpuA14), .cpuRw(cpuRw), .romCeN(romCeN),
    .cpuData(cpuData), .romData(romData), .ppuA10(ppuA10), .ppuA11(ppuA11),
    .prgHigh(prgS), .chrHigh(chrS), .ntA10(ntS), .flashWeN(weS), .flashOeN(oeS));

  function automatic logic [7:0] nextReg(logic [7:0] old, bit fl, logic a14,
      logic ceN, logic rw, logic [7:0] d, logic [7:0] r);
    if (!ceN && !rw && (!fl || a14)) return fl ? d : (d & r);
    return old;
  endfunction

  function automatic logic [4:0] expPrg(logic [7:0] rg, logic a14);
    return a14 ? 5'h1F : rg[4:0];
  endfunction

  function automatic logic [1:0] expChr(logic [7:0] rg, int kb);
    if (kb >= 32) return {rg[6], rg[5]};
    if (kb >= 16) return {1'b1, rg[5]};
    return 2'b11;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(string prgTag);
    string t;
    t = cpuA14 ? "R3" : prgTag;
    check({t, " locked prg"}, prgL, expPrg(mL, cpuA14));
    check({t, " flash prg"},  prgF, expPrg(mF, cpuA14));
    check({t, " small prg"},  prgS, expPrg(mS, cpuA14));
    check("R8 chr 32KB", chrL, expChr(mL, 32));
    check("R8 chr 16KB", chrF, expChr(mF, 16));
    check("R8 chr 8KB",  chrS, expChr(mS, 8));
    check("R9 one-screen", ntL, mL[7]);
    check("R9 vertical",   ntF, ppuA10);
    check("R9 horizontal", ntS, ppuA11);
    check("R6 flash weN", weF, !(!romCeN && !cpuRw && !cpuA14));
    check("R7 flash oeN", oeF, !(!romCeN && cpuRw));
    check("R7 locked weN", weL, 1);
    check("R7 locked oeN", oeL, 0);
    check("R7 small weN", weS, 1);
    check("R7 small oeN", oeS, 0);
  endtask

  // one bus cycle: drive, check combinational outputs with old register, clock
  task automatic busCycle(logic a14, logic rw, logic ceN, logic [7:0] d,
      logic [7:0] r, logic p10, logic p11, string prgTag);
    @(negedge clk);
    cpuA14 = a14; cpuRw = rw; romCeN = ceN; cpuData = d; romData = r;
    ppuA10 = p10; ppuA11 = p11;
    #1;
    checkAll(prgTag);
    @(posedge clk);
    mL = nextReg(mL, 1'b0, a14, ceN, rw, d, r);
    mF = nextReg(mF, 1'b1, a14, ceN, rw, d, r);
    mS = nextReg(mS, 1'b0, a14, ceN, rw, d, r);
  endtask

  task automatic readLow(string tag);
    busCycle(1'b0, 1'b1, 1'b0, 8'h00, $urandom, 1'b0, 1'b1, tag);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 locked prg reset", prgL, 0);
    check("R1 flash prg reset", prgF, 0);
    check("R1 one-screen reset", ntL, 0);
    check("R1 chr reset", chrL, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R4: bus conflict ANDing, locked only; R6: flash lower-window write is a strobe
    busCycle(1'b0, 1'b0, 1'b0, 8'hFF, 8'h0F, 1'b0, 1'b0, "R4");
    readLow("R4");
    check("R4 locked anded", prgL, 5'h0F);
    check("R6 flash unchanged", prgF, 5'h00);
    // R5: flash upper-window write takes data unmodified; R11 timing
    busCycle(1'b1, 1'b0, 1'b0, 8'hB5, 8'h22, 1'b1, 1'b0, "R11");
    readLow("R5");
    check("R5 flash raw data", prgF, 5'h15);
    check("R4 locked anded upper", prgL, 5'h00);
    check("R11 one-screen after load", ntL, 1'b0);
    // R11: write value visible only in following cycle
    busCycle(1'b0, 1'b0, 1'b0, 8'h9C, 8'hFF, 1'b0, 1'b0, "R11");
    readLow("R11");
    check("R11 locked next cycle", prgL, 5'h1C);
    check("R9 one-screen bit7", ntL, 1'b1);
    // R10: ignored writes / reads
    busCycle(1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, "R10");
    busCycle(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, "R10");
    readLow("R10");
    check("R10 locked kept", prgL, 5'h1C);

    // R3: fixed last bank for every register value
    for (int v = 0; v < 256; v++) begin
      busCycle(1'b1, 1'b0, 1'b0, v[7:0], 8'hFF, v[0], v[1], "R3");
      busCycle(1'b1, 1'b1, 1'b0, 8'h00, $urandom, v[2], v[3], "R3");
      readLow("R2");
    end

    // R9: all mirroring inputs combinations
    for (int p = 0; p < 4; p++)
      busCycle(1'b0, 1'b1, 1'b1, 8'h00, 8'h00, p[0], p[1], "R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      busCycle(rv[0], rv[1] & rv[2], rv[3] & rv[4], $urandom, $urandom,
               rv[5], rv[6], "R2");
    end

    finishRun();
  end
endmodule